// File: doc/BRIEF.md
# Eight-Bit Timer with Shared Prescaler

This block is an 8-bit up-counter with a sticky wrap flag. It counts either instruction-cycle pulses or edges on an external pin. The instruction-cycle pulse is made inside the block: it fires once every four system clocks. When the pin is the source, a control bit picks whether rising or falling edges count. One power-of-two prescaler sits in front of either the counter or a watchdog path, chosen by a single assignment bit. Three rate bits set the division ratio. When the prescaler belongs to the watchdog, the counter takes every source event undivided, and the block hands the divided instruction-cycle pulse to an external watchdog on `wdog_tick`.

Software can load the counter at any time. A load also empties the prescaler and holds the counter still for the next two instruction-cycle pulses. Two state machines drive the timing:

- **Phase generator.** It has states PH_Q1, PH_Q2, PH_Q3 and PH_Q4. It steps through them in that order, one per clock, and returns from PH_Q4 to PH_Q1. The instruction-cycle pulse is high while it is in PH_Q4.
- **Load-hold machine.** It has states HOLD_RUN, HOLD_A and HOLD_B.
  - A load moves it to HOLD_A from any state.
  - HOLD_A goes to HOLD_B on an instruction-cycle pulse.
  - HOLD_B goes back to HOLD_RUN on an instruction-cycle pulse.
  - The counter may only increment in HOLD_RUN.

Top module: `tmr8_shared_psc`

## Requirements
- R1: While reset is asserted, `tmr_value` is 0, `wrap_flag` is 0 and `wdog_tick` is 0.
- R2: With `sel_ext_src`=0 and `psc_to_wdog`=1, the counter increments once every four clocks. After reset is released, the first increment lands on the fourth rising clock edge.
- R3: With `psc_to_wdog`=0, the counter advances once per 2^(`psc_rate`+1) source events. On the internal source starting from reset, increment n lands on clock edge 4·n·2^(`psc_rate`+1).
- R4: With `psc_to_wdog`=1, `wdog_tick` pulses once every 2^(`psc_rate`) instruction-cycle pulses. With `psc_rate`=3, starting from reset, 128 clocks give 4 pulses and 32 counter increments.
- R5: With `psc_to_wdog`=0, `wdog_tick` carries every instruction-cycle pulse: 10 pulses in 40 clocks after reset.
- R6: With `sel_ext_src`=1 and `sel_fall_edge`=0, a low-to-high change of `t_pin` set up before clock edge k increments the counter on edge k+2. A high-to-low change does not count.
- R7: With `sel_ext_src`=1 and `sel_fall_edge`=1, only high-to-low changes of `t_pin` count, with the same two-edge latency.
- R8: `wrap_flag` sets when an increment takes the counter from FFh to 00h. Loading FFh does not set it.
- R9: `wrap_flag` stays at 1 until `flag_clr` is pulsed. If a wrap and `flag_clr` happen in the same cycle, the flag stays set.
- R10: A `load_en` cycle has these effects:
  - `load_val` is in the counter on the next edge.
  - The prescaler is cleared.
  - Increments are blocked until two further instruction-cycle pulses have passed.
  - A load takes priority over an increment in the same cycle.
- R11: With `sel_ext_src`=0, activity on `t_pin` has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_ext_src | input | 1 | 1: count `t_pin` edges; 0: count instruction-cycle pulses |
| sel_fall_edge | input | 1 | 1: falling pin edges count; 0: rising pin edges count |
| psc_to_wdog | input | 1 | 1: prescaler serves the watchdog path; 0: prescaler serves the counter |
| psc_rate | input | 3 | Prescaler ratio select |
| t_pin | input | 1 | Asynchronous external count input |
| load_en | input | 1 | Load strobe for the counter |
| load_val | input | 8 | Value to load |
| flag_clr | input | 1 | Clears `wrap_flag` |
| tmr_value | output | 8 | Current count |
| wrap_flag | output | 1 | Sticky FFh-to-00h wrap indicator |
| wdog_tick | output | 1 | Tick for the watchdog path, divided when the prescaler is assigned to it |

## Verification
The bound checker watches, on every cycle, the properties that can be seen at the ports alone:
- the counter only holds or steps by one unless a load occurs;
- a load lands exactly and the following cycle does not increment;
- the flag rises only on a true FFh-to-00h step;
- the flag stays set until a clear, and falls after a clear that coincides with no wrap.

The bench scenarios cover the rest:
- the exact division ratios for both prescaler assignments;
- the two-instruction-cycle hold after a load;
- the synchronizer latency and the edge polarity on the pin;
- the pin being ignored on the internal source;
- the set-wins collision between a wrap and a clear, by comparing against a cycle model under long random runs.

// File: rtl/tmr8_pkg.sv
`timescale 1ns/1ps
package tmr8_pkg;

    // Four-phase sequencer that produces the instruction-cycle pulse
    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    // Increment hold after a counter load
    typedef enum logic [1:0] {
        HOLD_RUN = 2'd0,
        HOLD_A   = 2'd1,
        HOLD_B   = 2'd2
    } hold_e;

endpackage

// File: rtl/tmr8_phase_gen.sv
`timescale 1ns/1ps
module tmr8_phase_gen
    import tmr8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic cyc_en
);

    phase_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_Q1;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_Q1: state_d = PH_Q2;
            PH_Q2: state_d = PH_Q3;
            PH_Q3: state_d = PH_Q4;
            PH_Q4: state_d = PH_Q1;
        endcase
    end

    always_comb begin
        cyc_en = (state_q == PH_Q4);
    end

endmodule

// File: rtl/tmr8_pin_sync.sv
`timescale 1ns/1ps
module tmr8_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sel_fall,
    output logic evt
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    always_comb begin
        if (sel_fall) evt = !chain_q[STAGES-1] &&  prev_q;
        else          evt =  chain_q[STAGES-1] && !prev_q;
    end

endmodule

// File: rtl/tmr8_prescaler.sv
`timescale 1ns/1ps
module tmr8_prescaler #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_evt,
    input  logic              to_wdog,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    localparam int PSC_W = 1 << RATE_W;

    logic [PSC_W-1:0] div_q;
    logic [PSC_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PSC_W; i++) begin
            if (to_wdog) mask[i] = (i <  int'(rate));
            else         mask[i] = (i <= int'(rate));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (clr)    div_q <= '0;
        else if (in_evt) div_q <= div_q + 1'b1;
    end

    always_comb begin
        tick = in_evt && ((div_q & mask) == mask);
    end

endmodule

// File: rtl/tmr8_shared_psc.sv
`timescale 1ns/1ps
module tmr8_shared_psc
    import tmr8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int RATE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_ext_src,
    input  logic              sel_fall_edge,
    input  logic              psc_to_wdog,
    input  logic [RATE_W-1:0] psc_rate,
    input  logic              t_pin,
    input  logic              load_en,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  tmr_value,
    output logic              wrap_flag,
    output logic              wdog_tick
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic  cyc_en, ext_evt, src_evt, psc_in, psc_tick, inc;
    hold_e hold_q, hold_d;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    tmr8_phase_gen u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc_en (cyc_en)
    );

    tmr8_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (t_pin),
        .sel_fall (sel_fall_edge),
        .evt      (ext_evt)
    );

    tmr8_prescaler #(.RATE_W(RATE_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load_en),
        .in_evt  (psc_in),
        .to_wdog (psc_to_wdog),
        .rate    (psc_rate),
        .tick    (psc_tick)
    );

    // Hold machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= HOLD_RUN;
        else        hold_q <= hold_d;
    end

    // Hold machine: transitions
    always_comb begin
        hold_d = hold_q;
        if (load_en) begin
            hold_d = HOLD_A;
        end else begin
            unique case (hold_q)
                HOLD_RUN: hold_d = HOLD_RUN;
                HOLD_A:   if (cyc_en) hold_d = HOLD_B;
                HOLD_B:   if (cyc_en) hold_d = HOLD_RUN;
                default:  hold_d = HOLD_RUN;
            endcase
        end
    end

    // Event routing and increment decision
    always_comb begin
        src_evt   = sel_ext_src ? ext_evt : cyc_en;
        psc_in    = psc_to_wdog ? cyc_en : (src_evt && (hold_q == HOLD_RUN));
        inc       = !load_en && (hold_q == HOLD_RUN) &&
                    (psc_to_wdog ? src_evt : psc_tick);
        wdog_tick = psc_to_wdog ? psc_tick : cyc_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load_en) cnt_q <= load_val;
        else if (inc)     cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                        flag_q <= 1'b0;
        else if (inc && cnt_q == CNT_MAX)  flag_q <= 1'b1;
        else if (flag_clr)                 flag_q <= 1'b0;
    end

    always_comb begin
        tmr_value = cnt_q;
        wrap_flag = flag_q;
    end

endmodule

// File: rtl/tmr8_shared_psc_chk.sv
`timescale 1ns/1ps
module tmr8_shared_psc_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic [CNT_W-1:0] load_val,
    input logic             flag_clr,
    input logic [CNT_W-1:0] tmr_value,
    input logic             wrap_flag
);

    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] FULL = '1;

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (tmr_value == $past(tmr_value)) || (tmr_value == $past(tmr_value) + ONE)); // R2

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> tmr_value == $past(load_val)); // R10

    AST_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en ##1 !load_en |=> tmr_value == $past(tmr_value)); // R10

    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_flag) |-> (tmr_value == '0) && ($past(tmr_value) == FULL)); // R8

    AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_flag && !flag_clr |=> wrap_flag); // R9

    AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && (tmr_value != FULL) |=> !wrap_flag); // R9

endmodule

bind tmr8_shared_psc tmr8_shared_psc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_val  (load_val),
    .flag_clr  (flag_clr),
    .tmr_value (tmr_value),
    .wrap_flag (wrap_flag)
);

// File: tb/tmr8_shared_psc_tb.sv
`timescale 1ns/1ps
module tmr8_shared_psc_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_ext_src = 1'b0, sel_fall_edge = 1'b0, psc_to_wdog = 1'b0;
    logic [2:0] psc_rate = 3'd0;
    logic       t_pin = 1'b0, load_en = 1'b0, flag_clr = 1'b0;
    logic [7:0] load_val = 8'd0;
    logic [7:0] tmr_value;
    logic       wrap_flag, wdog_tick;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    string ctag = "R3";

    // cycle model state
    int m_ph, m_s0, m_s1, m_prev, m_psc, m_hold, m_cnt, m_flag;

    always #2 clk = ~clk;

    tmr8_shared_psc u_dut (
        .clk(clk), .rst_n(rst_n), .sel_ext_src(sel_ext_src),
        .sel_fall_edge(sel_fall_edge), .psc_to_wdog(psc_to_wdog),
        .psc_rate(psc_rate), .t_pin(t_pin), .load_en(load_en),
        .load_val(load_val), .flag_clr(flag_clr), .tmr_value(tmr_value),
        .wrap_flag(wrap_flag), .wdog_tick(wdog_tick)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mask_of(input bit wd, input int rate);
        return wd ? ((1 << rate) - 1) : ((1 << (rate + 1)) - 1);
    endfunction

    // expected combinational quantities from model state and current inputs
    function automatic int m_cyc();
        return (m_ph == 3) ? 1 : 0;
    endfunction

    function automatic int m_src();
        int ext;
        ext = sel_fall_edge ? int'(m_s1 == 0 && m_prev == 1) : int'(m_s1 == 1 && m_prev == 0);
        return sel_ext_src ? ext : m_cyc();
    endfunction

    function automatic int m_pin();
        return psc_to_wdog ? m_cyc() : int'(m_src() == 1 && m_hold == 0);
    endfunction

    function automatic int m_ptick();
        int mk;
        mk = mask_of(psc_to_wdog, int'(psc_rate));
        return int'(m_pin() == 1 && ((m_psc & mk) == mk));
    endfunction

    function automatic int m_wdog();
        return psc_to_wdog ? m_ptick() : m_cyc();
    endfunction

    task automatic model_clear();
        m_ph = 0; m_s0 = 0; m_s1 = 0; m_prev = 0;
        m_psc = 0; m_hold = 0; m_cnt = 0; m_flag = 0;
    endtask

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            int cyc, src, pin, inc, n_hold, n_psc, n_cnt, n_flag;
            cyc = m_cyc();
            src = m_src();
            pin = m_pin();
            inc = int'(!load_en && m_hold == 0 &&
                       (psc_to_wdog ? src == 1 : m_ptick() == 1));
            if (load_en) n_hold = 1;
            else if (m_hold == 1 && cyc == 1) n_hold = 2;
            else if (m_hold == 2 && cyc == 1) n_hold = 0;
            else n_hold = m_hold;
            n_psc  = load_en ? 0 : (pin == 1 ? (m_psc + 1) & 255 : m_psc);
            n_cnt  = load_en ? int'(load_val) : (inc == 1 ? (m_cnt + 1) & 255 : m_cnt);
            n_flag = (inc == 1 && m_cnt == 255) ? 1 : (flag_clr ? 0 : m_flag);
            @(posedge clk);
            m_prev = m_s1; m_s1 = m_s0; m_s0 = int'(t_pin);
            m_ph = (m_ph + 1) % 4;
            m_hold = n_hold; m_psc = n_psc; m_cnt = n_cnt; m_flag = n_flag;
            #1;
            chk(ctag, int'(tmr_value), m_cnt);
            chk("R9", int'(wrap_flag), m_flag);
            chk("R4", int'(wdog_tick), m_wdog());
        end
    endtask

    task automatic do_reset(input bit ext, input bit fall, input bit wd, input int rate);
        rst_n = 1'b0;
        sel_ext_src = ext; sel_fall_edge = fall; psc_to_wdog = wd;
        psc_rate = 3'(rate);
        load_en = 0; flag_clr = 0; load_val = 0;
        @(posedge clk); @(posedge clk); #1;
        model_clear();
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        int wraps;
        seed = int'($urandom(32'h5EED1));

        // R1: reset state
        rst_n = 0; t_pin = 0;
        @(posedge clk); @(posedge clk); #1;
        chk("R1", int'(tmr_value), 0);
        chk("R1", int'(wrap_flag), 0);
        chk("R1", int'(wdog_tick), 0);

        // R2: internal source, undivided counter
        ctag = "R2";
        do_reset(0, 0, 1, 0);
        step(3);
        chk("R2", int'(tmr_value), 0);
        step(1);
        chk("R2", int'(tmr_value), 1);
        step(36);
        chk("R2", int'(tmr_value), 10);

        // R3: prescaler on the counter, several ratios
        ctag = "R3";
        for (int r = 0; r < 4; r++) begin
            do_reset(0, 0, 0, r);
            step(4 * (1 << (r + 1)) * 3 - 1);
            chk("R3", int'(tmr_value), 2);
            step(1);
            chk("R3", int'(tmr_value), 3);
        end

        // R4: prescaler on the watchdog path, rate 3
        ctag = "R4";
        begin
            int pulses = 0;
            do_reset(0, 0, 1, 3);
            for (int i = 0; i < 128; i++) begin
                step(1);
                pulses += int'(wdog_tick);
            end
            chk("R4", pulses, 4);
            chk("R4", int'(tmr_value), 32);
        end

        // R5: watchdog path undivided when prescaler serves the counter
        ctag = "R5";
        begin
            int pulses = 0;
            do_reset(0, 0, 0, 5);
            for (int i = 0; i < 40; i++) begin
                step(1);
                pulses += int'(wdog_tick);
            end
            chk("R5", pulses, 10);
        end

        // R11: pin toggling ignored on internal source
        ctag = "R11";
        do_reset(0, 0, 1, 0);
        for (int i = 0; i < 40; i++) begin
            t_pin = ~t_pin;
            step(1);
        end
        chk("R11", int'(tmr_value), 10);

        // R6: rising edges counted two edges later, falling ignored
        ctag = "R6";
        t_pin = 0;
        do_reset(1, 0, 1, 0);
        step(5);
        chk("R6", int'(tmr_value), 0);
        t_pin = 1;
        step(2);
        chk("R6", int'(tmr_value), 0);
        step(1);
        chk("R6", int'(tmr_value), 1);
        t_pin = 0;
        step(4);
        chk("R6", int'(tmr_value), 1);

        // R7: falling edges only
        ctag = "R7";
        t_pin = 1;
        do_reset(1, 1, 1, 0);
        step(5);
        chk("R7", int'(tmr_value), 0);
        t_pin = 0;
        step(2);
        chk("R7", int'(tmr_value), 0);
        step(1);
        chk("R7", int'(tmr_value), 1);

        // R10: load value, hold for two instruction-cycle pulses
        ctag = "R10";
        t_pin = 0;
        do_reset(0, 0, 1, 0);
        step(1);
        load_en = 1; load_val = 8'h40;
        step(1);
        load_en = 0;
        chk("R10", int'(tmr_value), 8'h40);
        step(9);
        chk("R10", int'(tmr_value), 8'h40);
        step(1);
        chk("R10", int'(tmr_value), 8'h41);

        // R8 / R9: wrap flag set, sticky, cleared
        ctag = "R8";
        do_reset(0, 0, 1, 0);
        step(1);
        load_en = 1; load_val = 8'hFF;
        step(1);
        load_en = 0;
        chk("R8", int'(wrap_flag), 0);
        for (int i = 0; i < 20 && tmr_value != 0; i++) step(1);
        chk("R8", int'(tmr_value), 0);
        chk("R8", int'(wrap_flag), 1);
        step(50);
        chk("R9", int'(wrap_flag), 1);
        flag_clr = 1;
        step(1);
        flag_clr = 0;
        chk("R9", int'(wrap_flag), 0);

        // random mix against the cycle model
        ctag = "R3";
        wraps = 0;
        do_reset(0, 0, 0, 0);
        for (int i = 0; i < 6000; i++) begin
            if (i % 300 == 0) begin
                sel_ext_src   = 1'($urandom % 2);
                sel_fall_edge = 1'($urandom % 2);
                psc_to_wdog   = 1'($urandom % 2);
                psc_rate      = 3'($urandom % 3);
            end
            if ($urandom % 3 == 0) t_pin = ~t_pin;
            load_en  = ($urandom % 60 == 0);
            load_val = ($urandom % 2 == 0) ? 8'(8'hF8 | ($urandom % 8)) : 8'($urandom);
            flag_clr = ($urandom % 8 == 0);
            step(1);
            if (wrap_flag && tmr_value == 0) wraps++;
        end
        load_en = 0; flag_clr = 0;
        tests++;
        if (wraps == 0) begin
            fails++;
            $display("FAIL R8: actual %0d wraps expected at least 1", wraps);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule